// File: doc/BRIEF.md
# Two-Word Burst SRAM Write Front End

This block models, one clock cycle per input edge, the input side of a synchronous SRAM that moves data in bursts of two words. One fast clock takes the place of the two input clock edges. An internal phase bit marks each cycle as a positive slot or a complementary slot, and the block shows it on `kpos_o`. When the load strobe is low in a positive slot, the block registers a command. The command carries the address and the direction: read or write.

The second word's address comes from a one-bit linear counter seeded with the address LSB. The second location is therefore the first address with bit 0 inverted.

- **Writes.** A write takes its first data word in the next positive slot and its second word in the complementary slot after that. Each word has its own lane enables. Both words are committed to the internal array at the edge where the second word arrives.
- **Reads.** A read samples the array at its command edge. It returns the two words on `q_o` over two consecutive cycles.

Top module: `b2f_sram_front`

## Requirements
- R1: A command is accepted only when `ld_n` is 0 at a positive-slot edge, that is, when `kpos_o` is 1 in the cycle before the edge. `ld_n` low in a complementary slot starts nothing: no array change and no read output.
- R2: The `rw` value sampled with an accepted command selects the direction. 1 means read, which never alters the array. 0 means write.
- R3: Every access covers two locations. The first word is at `addr`. The second word is at `addr` with bit 0 inverted, so an odd address pairs with the one below it.
- R4: For a write accepted at edge t, `d` is taken at edge t+2 as the first word and at edge t+3 as the second word. Both words are committed to the array at edge t+3.
- R5: `bws_n` is sampled with each data word and is active low. Bit i enables lane i, which is `d[9i+8:9i]`, for that word only.
- R6: A lane whose `bws_n` bit is 1 leaves the stored bits of that lane unchanged.
- R7: A write may be accepted in every positive slot. Consecutive writes stream one data word per cycle, and each burst lands at its own address.
- R8: `d` and `bws_n` have no effect when no write is pending. A pending write still completes with `ld_n` high and any value on `addr`.
- R9: For a read accepted at edge t, `q_o` shows the first word after edge t+2 and the second word after edge t+3. `q_valid_o` is 1 in those two cycles. When no read output is due, `q_valid_o` is 0 and `q_o` is 0.
- R10: A read samples the array at its own command edge. A read accepted before the commit edge of an earlier write returns the contents from before that write.
- R11: After reset, the array holds zeros, `q_valid_o` is 0, `q_o` is 0 and `kpos_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each edge is one input clock edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Load strobe, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr | input | AW | Word address of the first word |
| d | input | NB*LW | Write data word |
| bws_n | input | NB | Per-lane write enables, active low |
| kpos_o | output | 1 | 1 when the next edge is a positive slot |
| q_o | output | NB*LW | Read data word |
| q_valid_o | output | 1 | Read data is present on q_o |

## Verification
A full-array sweep writes every even-address pair and then every odd-address pair, each with data derived arithmetically from the address, and reads back every location. This exposes errors in the burst partner address and in word order. All sixteen combinations of first-word and second-word lane enables are applied over a known full-width pattern, which separates per-word lane sampling from lane merging. Further sequences cover these cases:
- back-to-back writes, to show that the write stages keep each burst separate;
- a read issued before an earlier write commits, to show the old contents are returned;
- load strobes in complementary slots, and data driven while idle, to show these cause no write and no read output.

// File: rtl/b2f_pkg.sv
package b2f_pkg;
   typedef enum logic {
      SLOT_POS = 1'b0,
      SLOT_NEG = 1'b1
   } slot_e;
endpackage

// File: rtl/b2f_phase.sv
module b2f_phase
   import b2f_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   always_ff @(posedge clk) begin
      if (!rst_n) slot <= SLOT_POS;
      else        slot <= (slot == SLOT_POS) ? SLOT_NEG : SLOT_POS;
   end
endmodule

// File: rtl/b2f_wr_pipe.sv
module b2f_wr_pipe #(
   parameter int AW = 8,
   parameter int NB = 2,
   parameter int LW = 9,
   localparam int DW = NB * LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_pos,
   input  logic          cmd_wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] d,
   input  logic [NB-1:0] bws_n,
   output logic          cm_v,
   output logic [AW-1:0] cm_a,
   output logic [DW-1:0] cm_w0,
   output logic [NB-1:0] cm_be0,
   output logic [DW-1:0] cm_w1,
   output logic [NB-1:0] cm_be1
);
   logic          s1_v, s2_v;
   logic [AW-1:0] s1_a, s2_a;
   logic [DW-1:0] w0_q;
   logic [NB-1:0] be0_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         s2_v  <= 1'b0;
         s1_a  <= '0;
         s2_a  <= '0;
         w0_q  <= '0;
         be0_q <= '0;
      end else if (is_pos) begin
         s1_v <= cmd_wr;
         if (cmd_wr) s1_a <= addr;
         s2_v <= s1_v;
         if (s1_v) begin
            s2_a  <= s1_a;
            w0_q  <= d;
            be0_q <= ~bws_n;
         end
      end else begin
         s2_v <= 1'b0;
      end
   end

   assign cm_v   = s2_v & ~is_pos;
   assign cm_a   = s2_a;
   assign cm_w0  = w0_q;
   assign cm_be0 = be0_q;
   assign cm_w1  = d;
   assign cm_be1 = ~bws_n;

   // R1
   cmd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s1_v) |-> !is_pos);
   // R7
   stage_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && is_pos) |=> s2_v);
   // R8
   pend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2_v |=> !s2_v);
endmodule

// File: rtl/b2f_array.sv
module b2f_array #(
   parameter int AW = 8,
   parameter int NB = 2,
   parameter int LW = 9,
   localparam int DW    = NB * LW,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cm_v,
   input  logic [AW-1:0] cm_a,
   input  logic [DW-1:0] cm_w0,
   input  logic [NB-1:0] cm_be0,
   input  logic [DW-1:0] cm_w1,
   input  logic [NB-1:0] cm_be1,
   input  logic [AW-1:0] rd_a,
   output logic [DW-1:0] rd_w0,
   output logic [DW-1:0] rd_w1
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] cm_a1, rd_a1;

   assign cm_a1 = {cm_a[AW-1:1], ~cm_a[0]};
   assign rd_a1 = {rd_a[AW-1:1], ~rd_a[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (cm_v) begin
         for (int i = 0; i < NB; i++) begin
            if (cm_be0[i]) mem[cm_a][i*LW +: LW]  <= cm_w0[i*LW +: LW];
            if (cm_be1[i]) mem[cm_a1][i*LW +: LW] <= cm_w1[i*LW +: LW];
         end
      end
   end

   assign rd_w0 = mem[rd_a];
   assign rd_w1 = mem[rd_a1];

   // R4
   one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_v |=> !cm_v);
endmodule

// File: rtl/b2f_rd_pipe.sv
module b2f_rd_pipe #(
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_pos,
   input  logic          cmd_rd,
   input  logic [DW-1:0] rd_w0,
   input  logic [DW-1:0] rd_w1,
   output logic [DW-1:0] q,
   output logic          qv
);
   logic          r1_v, hv;
   logic [DW-1:0] rb0, rb1, hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r1_v <= 1'b0;
         hv   <= 1'b0;
         rb0  <= '0;
         rb1  <= '0;
         hold <= '0;
         q    <= '0;
         qv   <= 1'b0;
      end else if (is_pos) begin
         r1_v <= cmd_rd;
         if (cmd_rd) begin
            rb0 <= rd_w0;
            rb1 <= rd_w1;
         end
         qv   <= r1_v;
         hv   <= r1_v;
         q    <= r1_v ? rb0 : '0;
         hold <= rb1;
      end else begin
         qv <= hv;
         q  <= hv ? hold : '0;
         hv <= 1'b0;
      end
   end

   // R9
   rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qv && !is_pos) |=> qv);
   // R9
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qv |-> (q == '0));
endmodule

// File: rtl/b2f_sram_front.sv
module b2f_sram_front
   import b2f_pkg::*;
#(
   parameter int AW = 8,
   parameter int NB = 2,
   parameter int LW = 9,
   localparam int DW = NB * LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_n,
   input  logic          rw,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] d,
   input  logic [NB-1:0] bws_n,
   output logic          kpos_o,
   output logic [DW-1:0] q_o,
   output logic          q_valid_o
);
   generate
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("AW must lie in 2..12");
      end
      if (NB < 1 || LW < 1) begin : g_bad_lane
         $error("NB and LW must be at least 1");
      end
   endgenerate

   slot_e         slot;
   logic          is_pos, cmd_rd, cmd_wr;
   logic          cm_v;
   logic [AW-1:0] cm_a;
   logic [DW-1:0] cm_w0, cm_w1, rd_w0, rd_w1;
   logic [NB-1:0] cm_be0, cm_be1;

   b2f_phase u_phase (.clk(clk), .rst_n(rst_n), .slot(slot));

   assign is_pos = (slot == SLOT_POS);
   assign cmd_rd = is_pos & ~ld_n & rw;
   assign cmd_wr = is_pos & ~ld_n & ~rw;

   b2f_wr_pipe #(.AW(AW), .NB(NB), .LW(LW)) u_wr (
      .clk(clk), .rst_n(rst_n), .is_pos(is_pos), .cmd_wr(cmd_wr),
      .addr(addr), .d(d), .bws_n(bws_n),
      .cm_v(cm_v), .cm_a(cm_a), .cm_w0(cm_w0), .cm_be0(cm_be0),
      .cm_w1(cm_w1), .cm_be1(cm_be1));

   b2f_array #(.AW(AW), .NB(NB), .LW(LW)) u_arr (
      .clk(clk), .rst_n(rst_n), .cm_v(cm_v), .cm_a(cm_a),
      .cm_w0(cm_w0), .cm_be0(cm_be0), .cm_w1(cm_w1), .cm_be1(cm_be1),
      .rd_a(addr), .rd_w0(rd_w0), .rd_w1(rd_w1));

   b2f_rd_pipe #(.DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .is_pos(is_pos), .cmd_rd(cmd_rd),
      .rd_w0(rd_w0), .rd_w1(rd_w1), .q(q_o), .qv(q_valid_o));

   assign kpos_o = is_pos;

   // R11
   reset_slot_chk: assert property (@(posedge clk)
      !rst_n |=> kpos_o);
endmodule

// File: tb/b2f_sram_front_bench.sv
module b2f_sram_front_bench;
   localparam int AW = 8, NB = 2, LW = 9, DW = NB * LW, DEPTH = 1 << AW;

   logic          clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, rw = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d = '0;
   logic [NB-1:0] bws_n = '1;
   logic          kpos_o, q_valid_o;
   logic [DW-1:0] q_o;

   logic [DW-1:0] refm [DEPTH];
   int            n_run = 0, n_fail = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   b2f_sram_front #(.AW(AW), .NB(NB), .LW(LW)) u_b2f_sram_front (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr), .d(d),
      .bws_n(bws_n), .kpos_o(kpos_o), .q_o(q_o), .q_valid_o(q_valid_o));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic l, input logic r, input logic [AW-1:0] a,
                        input logic [DW-1:0] dd, input logic [NB-1:0] bn);
      ld_n = l; rw = r; addr = a; d = dd; bws_n = bn;
      @(negedge clk);
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                           input logic [NB-1:0] bn);
      logic [DW-1:0] m = o;
      for (int i = 0; i < NB; i++) if (!bn[i]) m[i*LW +: LW] = n[i*LW +: LW];
      return m;
   endfunction

   function automatic logic [AW-1:0] mate(input logic [AW-1:0] a);
      return {a[AW-1:1], ~a[0]};
   endfunction

   function automatic logic [DW-1:0] pat(input int x, input int k);
      return DW'((x * 1237 + k * 4099 + 91) & ((1 << DW) - 1));
   endfunction

   // R4 R5 R6 R8: command, idle complementary slot with junk data, then two data words
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] w0, input logic [NB-1:0] b0,
                     input logic [DW-1:0] w1, input logic [NB-1:0] b1);
      drive(1'b0, 1'b0, a, ~w0, '0);
      drive(1'b1, 1'b0, a ^ 8'h5a, ~w1, '0);
      drive(1'b1, 1'b1, a ^ 8'h33, w0, b0);
      drive(1'b1, 1'b0, a ^ 8'hc1, w1, b1);
      refm[a]       = merge(refm[a], w0, b0);
      refm[mate(a)] = merge(refm[mate(a)], w1, b1);
   endtask

   // R2 R3 R9: read command, then check both words at t+2 and t+3
   task automatic rd(input logic [AW-1:0] a, input string tag);
      drive(1'b0, 1'b1, a, '0, '1);
      drive(1'b1, 1'b0, '0, '0, '1);
      drive(1'b1, 1'b0, '0, '0, '1);
      chk(q_valid_o && q_o == refm[a], tag, {q_valid_o, q_o}, {1'b1, refm[a]});
      drive(1'b1, 1'b0, '0, '0, '1);
      chk(q_valid_o && q_o == refm[mate(a)], tag, {q_valid_o, q_o}, {1'b1, refm[mate(a)]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < DEPTH; e++) refm[e] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk(kpos_o == 1'b1, "R11 kpos", 32'(kpos_o), 1);
      chk(q_valid_o == 1'b0 && q_o == '0, "R11 qout", {q_valid_o, q_o}, 0);
      rd(8'd5, "R11 array zero");

      // R3 even-address pair sweep
      for (int a = 0; a < DEPTH; a += 2) wr(AW'(a), pat(a, 0), '0, pat(a, 1), '0);
      for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R3 even sweep");
      // R3 odd-address pair sweep: second word lands one below
      for (int a = 1; a < DEPTH; a += 2) wr(AW'(a), pat(a, 2), '0, pat(a, 3), '0);
      for (int a = 0; a < DEPTH; a += 2) rd(AW'(a), "R3 odd sweep");

      // R5 R6 every lane-enable combination per word
      for (int b0 = 0; b0 < 4; b0++)
         for (int b1 = 0; b1 < 4; b1++) begin
            wr(8'd40, 18'h2aaaa, '0, 18'h15555, '0);
            wr(8'd40, pat(b0, b1), NB'(b0), pat(b1, b0 + 7), NB'(b1));
            rd(8'd40, "R5 R6 lane merge");
         end

      // R7 three back-to-back writes
      drive(1'b0, 1'b0, 8'd100, '0, '1);
      drive(1'b1, 1'b0, '0, '0, '1);
      drive(1'b0, 1'b0, 8'd103, 18'h00111, '0);
      drive(1'b1, 1'b0, '0, 18'h00222, '0);
      drive(1'b0, 1'b0, 8'd150, 18'h00333, '0);
      drive(1'b1, 1'b0, '0, 18'h00444, '0);
      drive(1'b1, 1'b0, '0, 18'h00555, '0);
      drive(1'b1, 1'b0, '0, 18'h00666, '0);
      refm[100] = 18'h00111; refm[101] = 18'h00222;
      refm[103] = 18'h00333; refm[102] = 18'h00444;
      refm[150] = 18'h00555; refm[151] = 18'h00666;
      rd(8'd100, "R7 b2b first");
      rd(8'd103, "R7 b2b second");
      rd(8'd150, "R7 b2b third");

      // R10 read issued before the write commits returns old contents
      begin
         logic [DW-1:0] o0, o1;
         o0 = refm[60]; o1 = refm[61];
         drive(1'b0, 1'b0, 8'd60, '0, '1);
         drive(1'b1, 1'b0, '0, '0, '1);
         drive(1'b0, 1'b1, 8'd60, 18'h3c3c3, '0);
         drive(1'b1, 1'b0, '0, 18'h1e1e1, '0);
         drive(1'b1, 1'b0, '0, '0, '1);
         chk(q_valid_o && q_o == o0, "R10 old word0", {q_valid_o, q_o}, {1'b1, o0});
         drive(1'b1, 1'b0, '0, '0, '1);
         chk(q_valid_o && q_o == o1, "R10 old word1", {q_valid_o, q_o}, {1'b1, o1});
         refm[60] = 18'h3c3c3; refm[61] = 18'h1e1e1;
         rd(8'd60, "R10 new after commit");
      end

      // R1 load strobe in complementary slot: no write, no read output
      drive(1'b1, 1'b0, '0, '0, '1);
      drive(1'b0, 1'b0, 8'd70, 18'h3ffff, '0);
      drive(1'b1, 1'b0, 8'd70, 18'h3ffff, '0);
      drive(1'b1, 1'b0, 8'd70, 18'h3ffff, '0);
      rd(8'd70, "R1 neg-slot write ignored");
      drive(1'b1, 1'b1, '0, '0, '1);
      drive(1'b0, 1'b1, 8'd70, '0, '1);
      drive(1'b1, 1'b1, '0, '0, '1);
      chk(!q_valid_o && q_o == '0, "R1 neg-slot read", {q_valid_o, q_o}, 0);
      drive(1'b1, 1'b1, '0, '0, '1);
      chk(!q_valid_o && q_o == '0, "R1 neg-slot read", {q_valid_o, q_o}, 0);

      // R8 data while idle is ignored
      for (int k = 0; k < 4; k++) drive(1'b1, 1'(k), 8'd80, 18'h0abcd, '0);
      rd(8'd80, "R8 idle data ignored");
      chk(q_valid_o == 1'b1, "R9 second word valid", 32'(q_valid_o), 1);
      drive(1'b1, 1'b0, '0, '0, '1);
      chk(!q_valid_o && q_o == '0, "R9 idle after burst", {q_valid_o, q_o}, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule